// File: doc/BRIEF.md
# 4x4 Forward Integer DCT Engine

This block takes a 4x4 tile of signed 16-bit residual samples and produces the sixteen coefficients of its forward integer discrete cosine transform. Samples arrive in row-major order, one per accepted valid/ready transfer. Each sample is first scaled up by sixteen, and the top-left sample gets a small bias. The tile then goes through two identical one-dimensional butterfly passes, with a transpose after each. A final rounding shift brings the values back to coefficient scale.

Coefficients leave in row-major order, one per accepted transfer, under a valid/ready handshake. A last-flag marks the final coefficient of the tile. The engine works on one tile at a time. It takes no new samples from the moment the sixteenth sample is captured until the downstream side has taken the sixteenth coefficient. All arithmetic is defined bit-exactly, including where 16-bit values wrap and where they saturate.

Top module: `dct4_fdct_engine`

## Requirements
- R1: Each captured sample is multiplied by 16 as a 16-bit left shift by four; bits shifted out of the top are lost, so the value wraps.
- R2: If the sample at row 0, column 0 is nonzero, 1 is added to its scaled value. If that sample is zero, or the sample is at any other position, no bias is added.
- R3: A pass works column by column on rows r0..r3 using wrapping 16-bit arithmetic: u=r0+r3, v=r1+r2, w=r1−r2, z=r0−r3. It produces four result rows:
  - row 0 = rnd(u·11585 + v·11585)
  - row 1 = rnd(z·15137 + w·6270)
  - row 2 = rnd(u·11585 − v·11585)
  - row 3 = rnd(z·6270 − w·15137)
- R4: rnd(x) adds 8192 to the full-precision value, shifts it arithmetically right by 14, and saturates the result to the range −32768..32767.
- R5: Exactly two passes are applied, and the 4x4 result is transposed after each one.
- R6: Each output coefficient equals (y+1) arithmetic-shifted right by 2. Here y is the value after the second pass, and the +1 is a 16-bit wrapping addition.
- R7: For input samples 1..16 in row-major order, the output in hex is 0110 ffdc 0000 fffd ff71 0000 0000 0000 0000 0000 0000 0000 fff6 0000 0000 0000.
- R8: inReady is high only while samples are being collected. It goes low after the sixteenth sample is accepted and stays low until the sixteenth coefficient is accepted. inValid has no effect while inReady is low.
- R9: outLast is high together with the sixteenth coefficient of a tile and at no other time.
- R10: After reset, inReady is 1, outValid and outLast are 0, and both the sample count and the coefficient count start from zero, so a tile that was partly loaded when reset came is discarded.
- R11: While outValid is high and outReady is low, outData and outLast hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample present on inData |
| inReady | output | 1 | Engine is collecting samples |
| inData | input | 16 | Signed residual sample |
| outValid | output | 1 | Coefficient present on outData |
| outReady | input | 1 | Downstream accepts the coefficient |
| outData | output | 16 | Signed transform coefficient |
| outLast | output | 1 | Marks the sixteenth coefficient of a tile |

## Verification
The sequence 1..16 is checked against a fixed table of expected coefficients, which pins down the whole chain of arithmetic. An all-zero tile and a tile whose only nonzero value sits in the top-left corner show whether the bias is applied under the right condition. Tiles at full-scale positive and negative values, and tiles whose scaled values wrap, reach the saturation and wrap boundaries. Seeded random tiles, both small-range and full-range, are fed with random input gaps and random output back-pressure and compared against a bench model; they also exercise holding under stall, the last-flag, input lockout while busy, and reset in the middle of a tile.

// File: rtl/dct4_pkg.sv
package dct4_pkg;
  localparam int COEF_W = 16;
  localparam int BLK_N  = 4;
  localparam int BLK_SZ = BLK_N * BLK_N;
  localparam int IDX_W  = $clog2(BLK_SZ);

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef coef_t [BLK_SZ-1:0] blk_t;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_PASS_A,
    ST_PASS_B,
    ST_EMIT
  } dct4_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             firstSample;
    logic [IDX_W-1:0] loadIdx;
    logic             passStep;
    logic [IDX_W-1:0] readIdx;
  } dct4_strobe_t;
endpackage

// File: rtl/dct4_pass.sv
module dct4_pass
  import dct4_pkg::*;
#(
  parameter int CONST_BITS = 14,
  parameter int C_MID      = 11585,
  parameter int C_HI       = 15137,
  parameter int C_LO       = 6270
) (
  input  blk_t blkIn,
  output blk_t blkOut
);
  localparam int ACC_W = 2 * COEF_W + 2;
  localparam logic signed [ACC_W-1:0] K_MID = ACC_W'(C_MID);
  localparam logic signed [ACC_W-1:0] K_HI  = ACC_W'(C_HI);
  localparam logic signed [ACC_W-1:0] K_LO  = ACC_W'(C_LO);
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (CONST_BITS - 1);
  localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'((1 << (COEF_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV  = -(MAXV + ACC_W'(1));

  // round to nearest at 2^CONST_BITS, then clamp into the coefficient range
  function automatic coef_t rndSat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] sh;
    sh = (acc + HALF) >>> CONST_BITS;
    if (sh > MAXV)      rndSat = MAXV[COEF_W-1:0];
    else if (sh < MINV) rndSat = MINV[COEF_W-1:0];
    else                rndSat = sh[COEF_W-1:0];
  endfunction

  for (genvar col = 0; col < BLK_N; col++) begin : g_col
    coef_t sumOut, sumIn, difIn, difOut;
    logic signed [ACC_W-1:0] eSumOut, eSumIn, eDifIn, eDifOut;

    // wrapping 16-bit first stage
    assign sumOut = blkIn[col] + blkIn[3*BLK_N + col];
    assign sumIn  = blkIn[BLK_N + col] + blkIn[2*BLK_N + col];
    assign difIn  = blkIn[BLK_N + col] - blkIn[2*BLK_N + col];
    assign difOut = blkIn[col] - blkIn[3*BLK_N + col];

    assign eSumOut = ACC_W'(sumOut);
    assign eSumIn  = ACC_W'(sumIn);
    assign eDifIn  = ACC_W'(difIn);
    assign eDifOut = ACC_W'(difOut);

    // results land transposed: pass row k, column col -> position col*N+k
    assign blkOut[col*BLK_N + 0] = rndSat(eSumOut * K_MID + eSumIn * K_MID);
    assign blkOut[col*BLK_N + 1] = rndSat(eDifOut * K_HI  + eDifIn * K_LO);
    assign blkOut[col*BLK_N + 2] = rndSat(eSumOut * K_MID - eSumIn * K_MID);
    assign blkOut[col*BLK_N + 3] = rndSat(eDifOut * K_LO  - eDifIn * K_HI);
  end
endmodule

// File: rtl/dct4_ctrl.sv
module dct4_ctrl
  import dct4_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output logic         outLast,
  output dct4_strobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_SZ - 1);

  dct4_state_t      state;
  logic [IDX_W-1:0] inCnt;
  logic [IDX_W-1:0] outCnt;

  always_comb begin
    inReady            = (state == ST_COLLECT);
    outValid           = (state == ST_EMIT);
    outLast            = outValid && (outCnt == LAST_IDX);
    strobe.load        = inValid && inReady;
    strobe.firstSample = (inCnt == '0);
    strobe.loadIdx     = inCnt;
    strobe.passStep    = (state == ST_PASS_A) || (state == ST_PASS_B);
    strobe.readIdx     = outCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_COLLECT;
      inCnt  <= '0;
      outCnt <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: if (inValid) begin
          inCnt <= inCnt + 1'b1;
          if (inCnt == LAST_IDX) state <= ST_PASS_A;
        end
        ST_PASS_A: state <= ST_PASS_B;
        ST_PASS_B: state <= ST_EMIT;
        ST_EMIT: if (outReady) begin
          outCnt <= outCnt + 1'b1;
          if (outCnt == LAST_IDX) state <= ST_COLLECT;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  p_lock_after_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCnt == LAST_IDX) |=> !inReady);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
  p_two_passes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS_A) |=> (state == ST_PASS_B));
  p_pass_then_emit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS_B) |=> outValid);
  p_last_reopens_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (inReady && !outValid));
  p_last_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLast) && $stable(outCnt)));
endmodule

// File: rtl/dct4_dpath.sv
module dct4_dpath
  import dct4_pkg::*;
#(
  parameter int PRESCALE_SH = 4,
  parameter int FINAL_SH    = 2,
  parameter int CONST_BITS  = 14,
  parameter int C_MID       = 11585,
  parameter int C_HI        = 15137,
  parameter int C_LO        = 6270
) (
  input  logic         clk,
  input  logic         rstN,
  input  dct4_strobe_t strobe,
  input  coef_t        inData,
  output coef_t        outData
);
  blk_t  tile;
  blk_t  passOut;
  coef_t scaled;
  coef_t picked;
  coef_t biased;

  dct4_pass #(
    .CONST_BITS(CONST_BITS),
    .C_MID     (C_MID),
    .C_HI      (C_HI),
    .C_LO      (C_LO)
  ) u_pass (
    .blkIn (tile),
    .blkOut(passOut)
  );

  always_comb begin
    scaled = inData <<< PRESCALE_SH;
    if (strobe.firstSample && inData != '0) scaled = scaled + coef_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tile <= '0;
    end else if (strobe.load) begin
      tile[strobe.loadIdx] <= scaled;
    end else if (strobe.passStep) begin
      tile <= passOut;
    end
  end

  always_comb begin
    picked  = tile[strobe.readIdx];
    biased  = picked + coef_t'(1);
    outData = biased >>> FINAL_SH;
  end

  p_tile_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.passStep) |=> $stable(tile));
  p_no_load_in_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passStep |-> !strobe.load);
endmodule

// File: rtl/dct4_fdct_engine.sv
module dct4_fdct_engine
  import dct4_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] inData,
  output logic        outValid,
  input  logic        outReady,
  output logic [15:0] outData,
  output logic        outLast
);
  dct4_strobe_t strobe;
  coef_t        coefOut;

  dct4_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .outLast (outLast),
    .strobe  (strobe)
  );

  dct4_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inData (coef_t'(inData)),
    .outData(coefOut)
  );

  assign outData = coefOut;
endmodule

// File: tb/dct4_fdct_engine_bench.sv
module dct4_fdct_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outData;
  logic        outLast;

  int checkCnt = 0;
  int failCnt = 0;
  int samp[16];
  logic [15:0] expv[16];

  always #2 clk = ~clk;

  dct4_fdct_engine u_dct4_fdct_engine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint w16(input longint x);
    longint t = x & 64'hFFFF;
    return (t >= 32768) ? t - 65536 : t;
  endfunction

  function automatic longint rnd14(input longint x);
    longint t = (x + 8192) >>> 14;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  // reference built from R1..R6
  function automatic void model();
    longint m[16];
    longint n[16];
    for (int i = 0; i < 16; i++) m[i] = w16(longint'(samp[i]) * 16);
    if (w16(samp[0]) != 0) m[0] = w16(m[0] + 1);
    for (int p = 0; p < 2; p++) begin
      for (int j = 0; j < 4; j++) begin
        longint u, v, w, z;
        u = w16(m[j] + m[12+j]);
        v = w16(m[4+j] + m[8+j]);
        w = w16(m[4+j] - m[8+j]);
        z = w16(m[j] - m[12+j]);
        n[j*4+0] = rnd14(u*11585 + v*11585);
        n[j*4+1] = rnd14(z*15137 + w*6270);
        n[j*4+2] = rnd14(u*11585 - v*11585);
        n[j*4+3] = rnd14(z*6270 - w*15137);
      end
      for (int i = 0; i < 16; i++) m[i] = n[i];
    end
    for (int i = 0; i < 16; i++) expv[i] = 16'(w16(m[i] + 1) >>> 2);
  endfunction

  task automatic runBlock(input string tag, input bit gaps);
    logic [15:0] held;
    bit stalled;
    int k;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      while (gaps && ($urandom % 4 == 0)) begin
        inValid = 1'b0; inData = 16'($urandom);
        @(negedge clk);
      end
      check(inReady == 1'b1, "R8 ready while collecting", int'(inReady), 1);
      inValid = 1'b1; inData = 16'(samp[i]);
    end
    @(negedge clk);
    inValid = 1'b1; inData = 16'($urandom);   // junk while busy, must be ignored (R8)
    check(inReady == 1'b0, "R8 locked after 16th sample", int'(inReady), 0);
    k = 0; stalled = 0; held = '0;
    while (k < 16) begin
      @(negedge clk);
      if (outValid) begin
        check(inReady == 1'b0, "R8 locked while emitting", int'(inReady), 0);
        if (stalled) check(outData == held, "R11 hold under stall", int'(outData), int'(held));
      end
      outReady = ($urandom % 3 != 0);
      if (outValid && outReady) begin
        check(outData == expv[k], tag, int'(outData), int'(expv[k]));
        check(outLast == (k == 15), "R9 last flag", int'(outLast), int'(k == 15));
        if (k == 15) inValid = 1'b0;
        k++; stalled = 0;
      end else if (outValid) begin
        stalled = 1; held = outData;
        check(outLast == (k == 15), "R9 last flag under stall", int'(outLast), int'(k == 15));
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    check(inReady == 1'b1 && outValid == 1'b0, "R8 reopens after last",
          int'({inReady, outValid}), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0 && outLast == 1'b0, "R10 reset state",
          int'({inReady, outValid, outLast}), 4);
    rstN = 1'b1;

    // R7: known sequence with literal expected table
    for (int i = 0; i < 16; i++) samp[i] = i + 1;
    expv = '{16'h0110, 16'hffdc, 16'h0000, 16'hfffd, 16'hff71, 16'h0000, 16'h0000, 16'h0000,
             16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hfff6, 16'h0000, 16'h0000, 16'h0000};
    runBlock("R7 reference tile", 1'b0);

    // R2: zero tile, no bias
    for (int i = 0; i < 16; i++) samp[i] = 0;
    model();
    runBlock("R2 zero tile no bias", 1'b1);

    // R2: only first sample nonzero, bias applied
    samp[0] = 1; model();
    runBlock("R2 first-sample bias", 1'b0);
    // R2: nonzero elsewhere only, no bias
    samp[0] = 0; samp[5] = -3; model();
    runBlock("R2 no bias off-corner", 1'b1);

    // R4 saturation, R6 16-bit final add
    for (int i = 0; i < 16; i++) samp[i] = 2047;
    model(); runBlock("R4 full-scale positive", 1'b0);
    for (int i = 0; i < 16; i++) samp[i] = -2048;
    model(); runBlock("R4 full-scale negative", 1'b1);
    for (int i = 0; i < 16; i++) samp[i] = (i % 2) ? 2047 : -2048;
    model(); runBlock("R6 alternating extremes", 1'b0);

    // R1: prescale wraps
    for (int i = 0; i < 16; i++) samp[i] = (i % 3 == 0) ? 32767 : 16'h1000;
    model(); runBlock("R1 prescale wrap", 1'b1);

    // R10: reset mid-tile discards partial load
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); inValid = 1'b1; inData = 16'($urandom);
    end
    @(negedge clk); inValid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R10 reset mid-tile",
          int'({inReady, outValid}), 2);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) samp[i] = 100 - 13 * i;
    model(); runBlock("R10 counters cleared", 1'b0);

    // R3/R5: random tiles
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 16; i++)
        samp[i] = (t % 2) ? int'($signed(16'($urandom))) : int'($urandom % 512) - 256;
      model();
      runBlock((t % 2) ? "R5 random full-range" : "R3 random small-range", 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule